// File: doc/BRIEF.md
# Configurable Logic-Cell Storage Register

This block is the storage element of one logic cell in a small programmable fabric. It takes a sum-of-products data term, a direct pin input, a set of global fabric clocks, and a group of per-cell and shared control terms. A static configuration word sets its behaviour. The register can act as an edge-triggered data flop, a toggle flop or a level-sensitive latch. Clocking can be single-edge or dual-edge. Its clock, set and reset each come from a selectable source.

All fabric clocks and control terms are treated as data and oversampled by one system clock `clk`. A fabric clock edge is therefore a change seen between two consecutive system-clock samples. Set and reset are level overrides that take hold on the next system edge. The configuration word is loaded only while `rst` is high and is frozen otherwise. Both outputs are registered.

The cell can also work as an input register that stores the pin signal. In that case the sum-of-products term stays visible on the pad path as a buried node, while the stored pin value goes to the feedback path.

Top module: `mc_reg_cell`

## Requirements
- R1: While `rst` is high, the stored state, `pad_o` and `fb_o` are cleared to 0 and every `cfg_*` input is captured. While `rst` is low, changes on `cfg_*` have no effect.
- R2: Mode code 0 (and the unused code 3) is the data flop. On each active edge of the selected clock, the state takes the data bit.
- R3: Mode code 1 is the toggle flop. On each active edge, the state inverts when the data bit is 1 and holds when it is 0.
- R4: Mode code 2 is the latch. The state follows the data bit while the selected clock is high and holds while it is low. Dual-edge and clock-enable settings have no effect in this mode.
- R5: With `cfg_dual`=1, falling edges of the selected clock are active as well as rising ones in modes 0 and 1. With `cfg_dual`=0, only rising edges are active.
- R6: In mode 0 with `cfg_ce_en`=1, an active edge while `pt_ce_i`=0 leaves the state unchanged. The enable is ignored in mode 1.
- R7: Clock source codes are: code k below NUM_GCK selects `gck_i[k]`; code NUM_GCK selects `pt_clk_i`; code NUM_GCK+1 selects `ct_clk_i`; any higher code selects no clock. Clocks that are not selected have no effect.
- R8: Set source codes are 0 none, 1 `pt_set_i`, 2 `ct_set_i`, 3 `gsr_i`. The selected set, while high, forces the state to 1 regardless of clocking.
- R9: Reset source codes are 0 none, 1 `pt_rst_i`, 2 `ct_rst_i`, 3 `gsr_i`. The selected reset, while high, forces the state to 0. When set and reset are both active, the state goes to 0.
- R10: With `cfg_pin_in`=1, the register stores `pin_i` instead of `sop_i`, `fb_o` carries the stored state, and `pad_o` carries `sop_i`.
- R11: With `cfg_pin_in`=0, `pad_o` and `fb_o` both carry `sop_i` when `cfg_comb_out`=1, and both carry the stored state otherwise.
- R12: In combinational output mode, a change on `sop_i` reaches `pad_o` one system clock later. A selected clock rise reaches `pad_o` two system clocks after it is first sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset; loads the configuration |
| cfg_mode | input | 2 | Storage mode: 0 data flop, 1 toggle flop, 2 latch |
| cfg_dual | input | 1 | Dual-edge clocking enable |
| cfg_ce_en | input | 1 | Use `pt_ce_i` as clock enable in data-flop mode |
| cfg_clk_src | input | CSEL_W | Clock source code |
| cfg_set_src | input | 2 | Set source code |
| cfg_rst_src | input | 2 | Reset source code |
| cfg_pin_in | input | 1 | Store the pin input (input-register use) |
| cfg_comb_out | input | 1 | Drive outputs from the combinational term |
| sop_i | input | 1 | Sum-of-products data term |
| pin_i | input | 1 | Direct pin input |
| gck_i | input | NUM_GCK | Global fabric clocks |
| pt_clk_i | input | 1 | Per-cell product-term clock |
| ct_clk_i | input | 1 | Shared control-term clock |
| pt_ce_i | input | 1 | Per-cell clock enable term |
| pt_set_i | input | 1 | Per-cell set term |
| ct_set_i | input | 1 | Shared set term |
| pt_rst_i | input | 1 | Per-cell reset term |
| ct_rst_i | input | 1 | Shared reset term |
| gsr_i | input | 1 | Global set/reset |
| pad_o | output | 1 | Value toward the pad path |
| fb_o | output | 1 | Value fed back to the interconnect |

## Verification
The bench changes the data between the rising and falling fabric-clock edges. A cell that ignored dual-edge capture would keep the old value, and one that captured on every edge would miss the single-edge case. It toggles a clock that is not selected and pulses set and reset sources that are not chosen, so a source multiplexer that leaked would disturb the state. It drives set and reset together to catch the wrong priority. It writes a new configuration without reset to catch a configuration register that is not frozen. It closes the latch and then changes the data, which exposes a latch that stays transparent. It also counts the exact cycles on the combinational and registered paths, so an extra or missing pipeline stage shows up.

// File: rtl/mc_pkg.sv
package mc_pkg;

  typedef enum logic [1:0] {
    MODE_DFF   = 2'd0,
    MODE_TFF   = 2'd1,
    MODE_LATCH = 2'd2,
    MODE_SPARE = 2'd3
  } st_mode_e;

  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_PTERM  = 2'd1,
    SRC_CTERM  = 2'd2,
    SRC_GLOBAL = 2'd3
  } sr_src_e;

  // clock candidates beyond the global clocks: product-term and control-term
  localparam int unsigned LOCAL_CLKS = 2;

endpackage

// File: rtl/mc_clk_pick.sv
module mc_clk_pick #(
  parameter int NUM_GCK = 3,
  parameter int CSEL_W  = 3
) (
  input  logic               clk,
  input  logic [CSEL_W-1:0]  sel_i,
  input  logic [NUM_GCK-1:0] gck_i,
  input  logic               pt_clk_i,
  input  logic               ct_clk_i,
  output logic               lvl_o,
  output logic               rise_o,
  output logic               fall_o
);
  import mc_pkg::*;

  localparam int NSRC = NUM_GCK + LOCAL_CLKS;

  logic [NSRC-1:0] cand;
  logic            prev_q;

  genvar g;
  generate
    for (g = 0; g < NUM_GCK; g++) begin : g_glob
      assign cand[g] = gck_i[g];
    end
  endgenerate
  assign cand[NUM_GCK]   = pt_clk_i;
  assign cand[NUM_GCK+1] = ct_clk_i;

  always_comb begin
    lvl_o = 1'b0;
    for (int k = 0; k < NSRC; k++) begin
      if (sel_i == CSEL_W'(k)) lvl_o = cand[k];
    end
  end

  // previous sample follows the selected level even in reset, so leaving
  // reset with a clock held high creates no false edge
  always_ff @(posedge clk) prev_q <= lvl_o;

  assign rise_o = lvl_o & ~prev_q;
  assign fall_o = ~lvl_o & prev_q;

endmodule

// File: rtl/mc_sr_pick.sv
module mc_sr_pick (
  input  logic [1:0] set_sel_i,
  input  logic [1:0] rst_sel_i,
  input  logic       pt_set_i,
  input  logic       ct_set_i,
  input  logic       pt_rst_i,
  input  logic       ct_rst_i,
  input  logic       gsr_i,
  output logic       set_o,
  output logic       clr_o
);
  import mc_pkg::*;

  logic set_raw, rst_raw;

  always_comb begin
    case (sr_src_e'(set_sel_i))
      SRC_PTERM:  set_raw = pt_set_i;
      SRC_CTERM:  set_raw = ct_set_i;
      SRC_GLOBAL: set_raw = gsr_i;
      default:    set_raw = 1'b0;
    endcase
    case (sr_src_e'(rst_sel_i))
      SRC_PTERM:  rst_raw = pt_rst_i;
      SRC_CTERM:  rst_raw = ct_rst_i;
      SRC_GLOBAL: rst_raw = gsr_i;
      default:    rst_raw = 1'b0;
    endcase
  end

  // clear dominates
  assign clr_o = rst_raw;
  assign set_o = set_raw & ~rst_raw;

endmodule

// File: rtl/mc_store.sv
module mc_store (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_i,
  input  logic       dual_i,
  input  logic       ce_en_i,
  input  logic       ce_i,
  input  logic       d_i,
  input  logic       lvl_i,
  input  logic       rise_i,
  input  logic       fall_i,
  input  logic       set_i,
  input  logic       clr_i,
  output logic       q_o
);
  import mc_pkg::*;

  logic      act_edge;
  logic      ce_ok;
  st_mode_e  mode;

  assign mode     = st_mode_e'(mode_i);
  assign act_edge = rise_i | (dual_i & fall_i);
  assign ce_ok    = ~ce_en_i | ce_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_o <= 1'b0;
    end else if (clr_i) begin
      q_o <= 1'b0;
    end else if (set_i) begin
      q_o <= 1'b1;
    end else begin
      case (mode)
        MODE_LATCH: if (lvl_i) q_o <= d_i;
        MODE_TFF:   if (act_edge) q_o <= q_o ^ d_i;
        default:    if (act_edge && ce_ok) q_o <= d_i;
      endcase
    end
  end

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !q_o); // R9
  AST_SET_FORCES: assert property (@(posedge clk) disable iff (rst)
    (set_i && !clr_i) |=> q_o); // R8
  AST_FLOP_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
    (mode != MODE_LATCH && !rise_i && !fall_i && !set_i && !clr_i) |=> $stable(q_o)); // R2
  AST_LATCH_CLOSED: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_LATCH && !lvl_i && !set_i && !clr_i) |=> $stable(q_o)); // R4
  AST_CE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    ((mode == MODE_DFF || mode == MODE_SPARE) && ce_en_i && !ce_i && !set_i && !clr_i)
      |=> $stable(q_o)); // R6

endmodule

// File: rtl/mc_reg_cell.sv
module mc_reg_cell #(
  parameter int NUM_GCK = 3,
  parameter int CSEL_W  = $clog2(NUM_GCK + 3)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         cfg_mode,
  input  logic               cfg_dual,
  input  logic               cfg_ce_en,
  input  logic [CSEL_W-1:0]  cfg_clk_src,
  input  logic [1:0]         cfg_set_src,
  input  logic [1:0]         cfg_rst_src,
  input  logic               cfg_pin_in,
  input  logic               cfg_comb_out,
  input  logic               sop_i,
  input  logic               pin_i,
  input  logic [NUM_GCK-1:0] gck_i,
  input  logic               pt_clk_i,
  input  logic               ct_clk_i,
  input  logic               pt_ce_i,
  input  logic               pt_set_i,
  input  logic               ct_set_i,
  input  logic               pt_rst_i,
  input  logic               ct_rst_i,
  input  logic               gsr_i,
  output logic               pad_o,
  output logic               fb_o
);

  // frozen configuration
  logic [1:0]        mode_q;
  logic              dual_q, ce_en_q, pin_q, comb_q;
  logic [CSEL_W-1:0] csel_q;
  logic [1:0]        ssel_q, rsel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= cfg_mode;
      dual_q  <= cfg_dual;
      ce_en_q <= cfg_ce_en;
      csel_q  <= cfg_clk_src;
      ssel_q  <= cfg_set_src;
      rsel_q  <= cfg_rst_src;
      pin_q   <= cfg_pin_in;
      comb_q  <= cfg_comb_out;
    end
  end

  logic lvl, rise, fall, set_a, clr_a, state, d_sel, out_val;

  mc_clk_pick #(.NUM_GCK(NUM_GCK), .CSEL_W(CSEL_W)) u_clk (
    .clk      (clk),
    .sel_i    (csel_q),
    .gck_i    (gck_i),
    .pt_clk_i (pt_clk_i),
    .ct_clk_i (ct_clk_i),
    .lvl_o    (lvl),
    .rise_o   (rise),
    .fall_o   (fall)
  );

  mc_sr_pick u_sr (
    .set_sel_i (ssel_q),
    .rst_sel_i (rsel_q),
    .pt_set_i  (pt_set_i),
    .ct_set_i  (ct_set_i),
    .pt_rst_i  (pt_rst_i),
    .ct_rst_i  (ct_rst_i),
    .gsr_i     (gsr_i),
    .set_o     (set_a),
    .clr_o     (clr_a)
  );

  assign d_sel = pin_q ? pin_i : sop_i;

  mc_store u_store (
    .clk     (clk),
    .rst     (rst),
    .mode_i  (mode_q),
    .dual_i  (dual_q),
    .ce_en_i (ce_en_q),
    .ce_i    (pt_ce_i),
    .d_i     (d_sel),
    .lvl_i   (lvl),
    .rise_i  (rise),
    .fall_i  (fall),
    .set_i   (set_a),
    .clr_i   (clr_a),
    .q_o     (state)
  );

  assign out_val = comb_q ? sop_i : state;

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_o <= 1'b0;
      fb_o  <= 1'b0;
    end else if (pin_q) begin
      pad_o <= sop_i;
      fb_o  <= state;
    end else begin
      pad_o <= out_val;
      fb_o  <= out_val;
    end
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable({mode_q, dual_q, ce_en_q, csel_q, ssel_q, rsel_q, pin_q, comb_q})); // R1
  AST_PIN_FEEDBACK: assert property (@(posedge clk) disable iff (rst)
    pin_q |=> (fb_o == $past(state) && pad_o == $past(sop_i))); // R10
  AST_COMB_PASS: assert property (@(posedge clk) disable iff (rst)
    (!pin_q && comb_q) |=> (pad_o == $past(sop_i) && fb_o == pad_o)); // R11

endmodule

// File: tb/tb_mc_reg_cell.sv
module tb_mc_reg_cell;

  localparam int NG = 3;
  localparam int CW = $clog2(NG + 3);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] cfg_mode;
  logic cfg_dual, cfg_ce_en, cfg_pin_in, cfg_comb_out;
  logic [CW-1:0] cfg_clk_src;
  logic [1:0] cfg_set_src, cfg_rst_src;
  logic sop, pin, pt_clk, ct_clk, pt_ce, pt_set, ct_set, pt_rst, ct_rst, gsr;
  logic [NG-1:0] gck;
  logic pad_o, fb_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  mc_reg_cell #(.NUM_GCK(NG)) dut (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_dual(cfg_dual),
    .cfg_ce_en(cfg_ce_en), .cfg_clk_src(cfg_clk_src), .cfg_set_src(cfg_set_src),
    .cfg_rst_src(cfg_rst_src), .cfg_pin_in(cfg_pin_in), .cfg_comb_out(cfg_comb_out),
    .sop_i(sop), .pin_i(pin), .gck_i(gck), .pt_clk_i(pt_clk), .ct_clk_i(ct_clk),
    .pt_ce_i(pt_ce), .pt_set_i(pt_set), .ct_set_i(ct_set), .pt_rst_i(pt_rst),
    .ct_rst_i(ct_rst), .gsr_i(gsr), .pad_o(pad_o), .fb_o(fb_o)
  );

  // {mode[1:0], dual, data, edges[2:0], expected}
  localparam int NV = 13;
  localparam logic [7:0] VEC [NV] = '{
    8'b00_0_1_001_1,  // D one rise
    8'b00_0_0_011_0,  // D data 0
    8'b01_0_1_001_1,  // T one rise
    8'b01_0_1_011_0,  // T two rises
    8'b01_0_1_101_1,  // T three rises
    8'b01_1_1_010_0,  // T dual, two active edges
    8'b01_1_1_011_1,  // T dual, three active edges
    8'b01_1_1_001_1,  // T dual, one edge
    8'b01_0_0_100_0,  // T data 0 holds
    8'b10_0_1_000_0,  // latch closed
    8'b10_0_1_001_1,  // latch open
    8'b10_1_1_010_1,  // latch opened then closed, dual ignored
    8'b11_0_1_001_1   // spare code acts as D
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0b expected %0b", tag, what, act, exp);
    end
  endtask

  task automatic defaults();
    cfg_mode = 2'd0; cfg_dual = 0; cfg_ce_en = 0; cfg_pin_in = 0; cfg_comb_out = 0;
    cfg_clk_src = '0; cfg_set_src = 2'd0; cfg_rst_src = 2'd0;
    sop = 0; pin = 0; gck = '0; pt_clk = 0; ct_clk = 0; pt_ce = 0;
    pt_set = 0; ct_set = 0; pt_rst = 0; ct_rst = 0; gsr = 0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(3);
    rst = 1'b0;
    step(1);
  endtask

  // 0..2 global clocks, 3 product-term clock, 4 control-term clock
  task automatic clk_pulse(input int which);
    case (which)
      0, 1, 2: gck[which] = 1'b1;
      3: pt_clk = 1'b1;
      default: ct_clk = 1'b1;
    endcase
    step(3);
    gck = '0; pt_clk = 0; ct_clk = 0;
    step(3);
  endtask

  // 0 pt_set, 1 ct_set, 2 pt_rst, 3 ct_rst, 4 gsr
  task automatic sr_pulse(input int which);
    case (which)
      0: pt_set = 1; 1: ct_set = 1; 2: pt_rst = 1; 3: ct_rst = 1; default: gsr = 1;
    endcase
    step(3);
    pt_set = 0; ct_set = 0; pt_rst = 0; ct_rst = 0; gsr = 0;
    step(3);
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    defaults();
    step(1);

    // R1: reset state
    sop = 1; cfg_set_src = 2'd3; gsr = 1;
    step(3);
    chk("R1", pad_o, 1'b0, "pad during reset");
    chk("R1", fb_o, 1'b0, "fb during reset");
    defaults();
    do_reset();
    step(2);
    chk("R1", pad_o, 1'b0, "pad after reset");
    chk("R1", fb_o, 1'b0, "fb after reset");

    // table walk, fabric clock on gck[0]
    for (int i = 0; i < NV; i++) begin
      logic [7:0] v;
      string tag;
      v = VEC[i];
      defaults();
      cfg_mode = v[7:6]; cfg_dual = v[5]; sop = v[4];
      do_reset();
      for (int e = 0; e < int'(v[3:1]); e++) begin
        gck[0] = ~gck[0];
        step(3);
      end
      tag = (v[7:6] == 2'd1) ? "R3" : (v[7:6] == 2'd2) ? "R4" : "R2";
      chk(tag, pad_o, v[0], $sformatf("vector %0d (R5 when dual)", i));
      gck = '0;
      step(2);
    end

    // R1: config change without reset is ignored (D stays D)
    defaults(); do_reset();
    cfg_mode = 2'd1; sop = 1;
    clk_pulse(0); clk_pulse(0);
    chk("R1", pad_o, 1'b1, "config change without reset");

    // R5: data changes between rise and fall
    defaults(); cfg_dual = 1; do_reset();
    sop = 1; gck[0] = 1; step(3); sop = 0; gck[0] = 0; step(3);
    chk("R5", pad_o, 1'b0, "dual edge captures on fall");
    defaults(); do_reset();
    sop = 1; gck[0] = 1; step(3); sop = 0; gck[0] = 0; step(3);
    chk("R5", pad_o, 1'b1, "single edge ignores fall");

    // R6: clock enable
    defaults(); cfg_ce_en = 1; do_reset();
    sop = 1; pt_ce = 0; clk_pulse(0);
    chk("R6", pad_o, 1'b0, "enable low holds");
    pt_ce = 1; clk_pulse(0);
    chk("R6", pad_o, 1'b1, "enable high loads");
    defaults(); cfg_mode = 2'd1; cfg_ce_en = 1; do_reset();
    sop = 1; pt_ce = 0; clk_pulse(0);
    chk("R6", pad_o, 1'b1, "enable ignored in toggle mode");

    // R4: latch holds after closing
    defaults(); cfg_mode = 2'd2; cfg_ce_en = 1; do_reset();
    sop = 1; gck[0] = 1; step(3);
    chk("R4", pad_o, 1'b1, "latch transparent, enable ignored");
    gck[0] = 0; step(2); sop = 0; step(3);
    chk("R4", pad_o, 1'b1, "latch closed holds");

    // R7: clock sources
    defaults(); cfg_clk_src = CW'(NG); do_reset();
    sop = 1; clk_pulse(0); clk_pulse(4);
    chk("R7", pad_o, 1'b0, "unselected clocks ignored");
    clk_pulse(3);
    chk("R7", pad_o, 1'b1, "product-term clock");
    defaults(); cfg_clk_src = CW'(NG + 1); do_reset();
    sop = 1; clk_pulse(3);
    chk("R7", pad_o, 1'b0, "pt clock ignored when ct selected");
    clk_pulse(4);
    chk("R7", pad_o, 1'b1, "control-term clock");
    defaults(); cfg_clk_src = CW'(2); do_reset();
    sop = 1; clk_pulse(0); clk_pulse(1);
    chk("R7", pad_o, 1'b0, "gck0/gck1 ignored");
    clk_pulse(2);
    chk("R7", pad_o, 1'b1, "global clock 2");
    defaults(); cfg_clk_src = CW'(NG + 2); do_reset();
    sop = 1;
    for (int s = 0; s < 5; s++) clk_pulse(s);
    chk("R7", pad_o, 1'b0, "no-clock code");

    // R8: set sources
    defaults(); cfg_set_src = 2'd1; do_reset();
    sr_pulse(1); sr_pulse(4);
    chk("R8", pad_o, 1'b0, "unselected sets ignored");
    sr_pulse(0);
    chk("R8", pad_o, 1'b1, "pt set");
    defaults(); cfg_set_src = 2'd0; do_reset();
    sr_pulse(0); sr_pulse(1); sr_pulse(4);
    chk("R8", pad_o, 1'b0, "set tied off");
    defaults(); cfg_set_src = 2'd3; do_reset();
    sr_pulse(4);
    chk("R8", pad_o, 1'b1, "global set");
    defaults(); cfg_set_src = 2'd2; do_reset();
    sop = 0; ct_set = 1; clk_pulse(0);
    chk("R8", pad_o, 1'b1, "set overrides clocked 0");
    ct_set = 0;

    // R9: reset sources and priority
    defaults(); cfg_rst_src = 2'd2; do_reset();
    sop = 1; clk_pulse(0);
    sr_pulse(2); sr_pulse(4);
    chk("R9", pad_o, 1'b1, "unselected resets ignored");
    sr_pulse(3);
    chk("R9", pad_o, 1'b0, "ct reset");
    defaults(); cfg_set_src = 2'd3; cfg_rst_src = 2'd3; do_reset();
    sop = 1; clk_pulse(0);
    sr_pulse(4);
    chk("R9", pad_o, 1'b0, "global on both: reset wins");
    defaults(); cfg_set_src = 2'd1; cfg_rst_src = 2'd1; do_reset();
    pt_set = 1; pt_rst = 1; step(3);
    chk("R9", pad_o, 1'b0, "set and reset together");
    pt_rst = 0; step(3);
    chk("R8", pad_o, 1'b1, "set alone after reset drops");
    pt_set = 0;

    // R10: input register
    defaults(); cfg_pin_in = 1; do_reset();
    pin = 1; sop = 0; clk_pulse(0);
    chk("R10", fb_o, 1'b1, "feedback carries stored pin");
    chk("R10", pad_o, 1'b0, "pad carries sop");
    sop = 1; pin = 0; step(3);
    chk("R10", pad_o, 1'b1, "pad follows sop");
    chk("R10", fb_o, 1'b1, "stored pin held without clock");

    // R11 / R12: combinational output and latency
    defaults(); cfg_comb_out = 1; do_reset();
    sop = 1; step(3);
    chk("R11", pad_o, 1'b1, "pad carries sop");
    chk("R11", fb_o, 1'b1, "fb carries sop");
    sop = 0; step(1);
    chk("R12", pad_o, 1'b0, "sop to pad in one cycle");
    defaults(); do_reset();
    sop = 1; gck[0] = 1; step(1);
    chk("R12", pad_o, 1'b0, "clock rise not yet at pad");
    step(1);
    chk("R12", pad_o, 1'b1, "clock rise at pad after two");
    chk("R11", fb_o, 1'b1, "fb carries state");
    gck = '0; step(2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule